// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block accepts configuration words over a three-wire serial link made of a data line, a serial clock and a load strobe. All three lines are brought into the system clock domain through two-flop synchronisers. Edges are then detected on the synchronised levels. Each synchronised rising edge of the serial clock shifts one data bit into a 24-bit shift register, most significant bit first. A rising edge on the load strobe copies the whole shifted word into one of four configuration latches. The two bits shifted in last pick that latch.

The latch contents leave the block on one flat bus, with latch k in slice k. Two general-purpose output pins follow two fixed bits of latch 1, which holds the intermediate-frequency divider word. Every completed load raises a one-cycle update strobe that carries the latch address.

A timing guard measures, in system clock cycles, the width of every serial clock phase and the delay from the last serial clock rise to the load strobe. If a minimum is not met, the load is refused and a one-cycle timing error strobe is raised instead. Neither strobe has back-pressure: both are single-cycle event pulses with no ready input, and a consumer that misses one cannot stall the block.

Top module: `ser_cfg_loader`

## Requirements
- R1: Every synchronised rising edge of `ser_clk` shifts the current `ser_data` level into a 24-bit shift register at bit 0. Earlier bits move toward bit 23, so the first bit sent ends up as the most significant bit.
- R2: On an accepted load, the full 24-bit shifted word is written into latch `word[1:0]`, the last two bits shifted in. Latch k appears on `cfg_flat[k*24 +: 24]`.
- R3: A transfer happens only on a rising edge of `ser_le`. Shifting while `ser_le` stays high, and the falling edge of `ser_le`, write nothing and raise no strobe.
- R4: A latch that is not addressed by a load keeps its value.
- R5: While `rst` is high and after it is released, all latches are zero, `gpo` is 0, and `upd_vld` and `tim_err` are low.
- R6: `gpo[0]` equals bit 17 of latch 1 and `gpo[1]` equals bit 18 of latch 1. Loads into other latches do not change `gpo`.
- R7: Each accepted load raises `upd_vld` for exactly one cycle, with `upd_addr` equal to the destination latch index.
- R8: When more than 24 bits are shifted before a load, only the last 24 are kept.
- R9: If any `ser_clk` high or low phase since the previous load edge lasts fewer than MIN_PHASE system cycles (default 8), the next `ser_le` rise writes nothing. Instead `tim_err` pulses for one cycle, and the following correctly timed load is accepted again.
- R10: A `ser_le` rise that comes fewer than MIN_CK2LE system cycles (default 16) after the last `ser_clk` rise writes nothing and pulses `tim_err`. `upd_vld` and `tim_err` are never high together.
- R11: After `ser_le` rises between two system clock edges, the addressed latch and `upd_vld` change at the third rising edge of `clk`, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; rising edge transfers the word |
| cfg_flat | output | 96 | Four 24-bit latches, latch k at [k*24 +: 24] |
| gpo | output | 2 | Pins following bits 17 and 18 of latch 1 |
| upd_vld | output | 1 | One-cycle strobe per accepted load |
| upd_addr | output | 2 | Address of the latch just written |
| tim_err | output | 1 | One-cycle strobe per refused load |

## Verification
The bench runs a table of words through the loader that covers every latch address. The words have dense, sparse, all-ones and alternating bit patterns, which separate a correct MSB-first order from a reversed or shifted one and a correct address decode from a wrong one. Some words carry different combinations of bits 17 and 18 into latch 1, while others land in other latches, which shows whether the output pins follow the right latch. Directed runs then cover overlong words, a held load strobe, a too-short clock phase, a too-early load strobe, and the exact cycle on which a load appears.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int WORD_W_DEF = 24;
  localparam int ADDR_W_DEF = 2;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int N = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N-1:0]             din,
  output scl_pkg::edge_t [N-1:0]   ev
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign ev[i].lvl  = s2[i];
    assign ev[i].rise = s2[i] & ~s3[i];
    assign ev[i].fall = ~s2[i] & s3[i];

    // R1: a detected edge lasts one cycle
    p_edge_single_r1: assert property (@(posedge clk) disable iff (rst)
      ev[i].rise |=> !ev[i].rise);
  end
endmodule

// File: rtl/scl_shift.sv
module scl_shift #(
  parameter int W = scl_pkg::WORD_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end

  p_msb_first_r1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (word[0] == $past(din)));
  p_shift_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(word));
endmodule

// File: rtl/scl_guard.sv
module scl_guard #(
  parameter int MIN_PHASE = 8,
  parameter int MIN_CK2LE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ck_rise,
  input  logic ck_fall,
  input  logic le_rise,
  output logic accept,
  output logic tim_err
);
  localparam int PW = $clog2(MIN_PHASE + 1);
  localparam int CW = $clog2(MIN_CK2LE + 1);
  localparam logic [PW-1:0] PH_MIN = PW'(MIN_PHASE);
  localparam logic [CW-1:0] CK_MIN = CW'(MIN_CK2LE);

  logic [PW-1:0] ph_cnt;
  logic [CW-1:0] ck_cnt;
  logic          bad_q;
  logic          ph_viol, bad_now, setup_ok;

  assign ph_viol  = (ck_rise | ck_fall) && (ph_cnt < PH_MIN);
  assign bad_now  = bad_q | ph_viol;
  assign setup_ok = !ck_rise && (ck_cnt >= CK_MIN);
  assign accept   = le_rise && !bad_now && setup_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_cnt  <= PH_MIN;
      ck_cnt  <= CK_MIN;
      bad_q   <= 1'b0;
      tim_err <= 1'b0;
    end else begin
      if (ck_rise | ck_fall)  ph_cnt <= PW'(1);
      else if (ph_cnt < PH_MIN) ph_cnt <= ph_cnt + PW'(1);

      if (ck_rise)            ck_cnt <= CW'(1);
      else if (ck_cnt < CK_MIN) ck_cnt <= ck_cnt + CW'(1);

      if (le_rise)      bad_q <= 1'b0;
      else if (ph_viol) bad_q <= 1'b1;

      tim_err <= le_rise && !accept;
    end
  end

  p_accept_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
    accept |-> le_rise);
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    tim_err |=> !tim_err);
endmodule

// File: rtl/scl_bank.sv
module scl_bank #(
  parameter int W        = scl_pkg::WORD_W_DEF,
  parameter int AW       = scl_pkg::ADDR_W_DEF,
  parameter int GPO_ADDR = 1,
  parameter int GPO0_BIT = 17,
  parameter int GPO1_BIT = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [W-1:0]            wr_word,
  output logic [(1<<AW)*W-1:0]    cfg_flat,
  output logic [1:0]              gpo,
  output logic                    upd_vld,
  output logic [AW-1:0]           upd_addr
);
  localparam int NL = 1 << AW;

  logic [AW-1:0] wa;
  logic [W-1:0]  lat [NL];

  assign wa = wr_word[AW-1:0];

  for (genvar k = 0; k < NL; k++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst)                         lat[k] <= '0;
      else if (wr_en && wa == AW'(k))  lat[k] <= wr_word;
    end
    assign cfg_flat[k*W +: W] = lat[k];

    // R4: a latch only changes after a write addressed to it
    p_lat_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (lat[k] != $past(lat[k])) |-> $past(wr_en && wa == AW'(k)));
  end

  assign gpo = {lat[GPO_ADDR][GPO1_BIT], lat[GPO_ADDR][GPO0_BIT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_vld  <= 1'b0;
      upd_addr <= '0;
    end else begin
      upd_vld <= wr_en;
      if (wr_en) upd_addr <= wa;
    end
  end

  p_gpo_src_r6: assert property (@(posedge clk) disable iff (rst)
    (gpo != $past(gpo)) |-> $past(wr_en && wa == AW'(GPO_ADDR)));
  p_upd_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    upd_vld |=> !upd_vld);
endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader #(
  parameter int WORD_W    = scl_pkg::WORD_W_DEF,
  parameter int ADDR_W    = scl_pkg::ADDR_W_DEF,
  parameter int MIN_PHASE = 8,
  parameter int MIN_CK2LE = 16,
  parameter int GPO_ADDR  = 1,
  parameter int GPO0_BIT  = 17,
  parameter int GPO1_BIT  = 18
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ser_clk,
  input  logic                              ser_data,
  input  logic                              ser_le,
  output logic [(1<<ADDR_W)*WORD_W-1:0]     cfg_flat,
  output logic [1:0]                        gpo,
  output logic                              upd_vld,
  output logic [ADDR_W-1:0]                 upd_addr,
  output logic                              tim_err
);
  localparam int I_CK = 0;
  localparam int I_DT = 1;
  localparam int I_LE = 2;

  scl_pkg::edge_t [2:0] ev;
  logic [WORD_W-1:0]    sh_word;
  logic                 accept;

  scl_sync #(.N(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ser_le, ser_data, ser_clk}),
    .ev  (ev)
  );

  scl_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (ev[I_CK].rise),
    .din      (ev[I_DT].lvl),
    .word     (sh_word)
  );

  scl_guard #(.MIN_PHASE(MIN_PHASE), .MIN_CK2LE(MIN_CK2LE)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .ck_rise (ev[I_CK].rise),
    .ck_fall (ev[I_CK].fall),
    .le_rise (ev[I_LE].rise),
    .accept  (accept),
    .tim_err (tim_err)
  );

  scl_bank #(
    .W(WORD_W), .AW(ADDR_W), .GPO_ADDR(GPO_ADDR),
    .GPO0_BIT(GPO0_BIT), .GPO1_BIT(GPO1_BIT)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept),
    .wr_word  (sh_word),
    .cfg_flat (cfg_flat),
    .gpo      (gpo),
    .upd_vld  (upd_vld),
    .upd_addr (upd_addr)
  );

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(upd_vld && tim_err));
  p_load_needs_le_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_vld || tim_err) |-> $past(ev[I_LE].rise));
endmodule

// File: tb/test_ser_cfg_loader.sv
module test_ser_cfg_loader;
  localparam int PH = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [95:0] cfg_flat;
  logic [1:0]  gpo, upd_addr;
  logic        upd_vld, tim_err;

  int n_chk = 0, n_fail = 0, upd_cnt = 0, err_cnt = 0;
  logic [1:0]  last_addr = '0;
  logic [23:0] mdl [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  ser_cfg_loader i_ser_cfg_loader (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .cfg_flat(cfg_flat), .gpo(gpo), .upd_vld(upd_vld), .upd_addr(upd_addr), .tim_err(tim_err)
  );

  always @(negedge clk) if (!rst) begin
    if (upd_vld) begin upd_cnt++; last_addr = upd_addr; end
    if (tim_err) err_cnt++;
  end

  localparam logic [23:0] VEC [7] = '{
    24'hA5C301, 24'h123456, 24'hFFFFFF, 24'h0F0F00,
    24'h060005, 24'h8000FE, 24'h000001
  };

  function automatic logic [23:0] lat(int k);
    return cfg_flat[k*24 +: 24];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] v, int nbits, int hi);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = v[i];
      wait_cyc(PH);
      ser_clk = 1'b1;
      wait_cyc(hi);
      ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_le(int setup);
    wait_cyc(setup);
    ser_le = 1'b1;
    wait_cyc(PH);
    ser_le = 1'b0;
    wait_cyc(PH);
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < 4; k++)
      check(lat(k) == mdl[k], req, {8'h0, lat(k)}, {8'h0, mdl[k]});
    check(gpo == {mdl[1][18], mdl[1][17]}, "R6 gpo", {30'h0, gpo}, {30'h0, mdl[1][18], mdl[1][17]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int u0, e0;
    logic [23:0] w;
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    wait_cyc(3);
    // R5: state during reset
    check(cfg_flat == '0, "R5 latches in reset", cfg_flat[31:0], 0);
    check(!upd_vld && !tim_err, "R5 strobes in reset", {upd_vld, tim_err}, 0);
    rst = 1'b0;
    wait_cyc(5);
    check_all("R5 latches after reset");
    check(upd_cnt == 0 && err_cnt == 0, "R5 no strobe after reset", upd_cnt, 0);

    // R1 R2 R4 R6 R7: table of words
    for (int v = 0; v < 7; v++) begin
      u0 = upd_cnt;
      send_bits({8'h0, VEC[v]}, 24, PH);
      pulse_le(PH);
      mdl[VEC[v][1:0]] = VEC[v];
      check(upd_cnt == u0 + 1, "R7 one update strobe", upd_cnt, u0 + 1);
      check(last_addr == VEC[v][1:0], "R7 update address", last_addr, VEC[v][1:0]);
      check_all("R2 R4 latch contents");
    end

    // R8: 30 bits shifted, last 24 kept
    send_bits({2'b0, 6'h2B, 24'h5A5A5B}, 30, PH);
    pulse_le(PH);
    mdl[3] = 24'h5A5A5B;
    check_all("R8 overlong word");

    // R3: held load strobe does not transfer again
    send_bits({8'h0, 24'h13579E}, 24, PH);
    wait_cyc(PH);
    ser_le = 1'b1;
    wait_cyc(PH);
    mdl[2] = 24'h13579E;
    u0 = upd_cnt;
    send_bits({8'h0, 24'hCAFE00}, 24, PH);
    wait_cyc(PH);
    check(upd_cnt == u0, "R3 no load while held high", upd_cnt, u0);
    check(lat(0) == mdl[0], "R3 latch0 untouched while held", {8'h0, lat(0)}, {8'h0, mdl[0]});
    ser_le = 1'b0;
    wait_cyc(PH);
    check(upd_cnt == u0, "R3 no load on falling edge", upd_cnt, u0);
    check_all("R3 latches after held strobe");

    // R9: short clock phase refuses the load
    u0 = upd_cnt; e0 = err_cnt;
    send_bits({8'h0, 24'hDEAD02}, 24, 3);
    pulse_le(PH);
    check(err_cnt == e0 + 1, "R9 timing error pulse", err_cnt, e0 + 1);
    check(upd_cnt == u0, "R9 no update", upd_cnt, u0);
    check_all("R9 latches unchanged");
    send_bits({8'h0, 24'h4C4C02}, 24, PH);
    pulse_le(PH);
    mdl[2] = 24'h4C4C02;
    check(upd_cnt == u0 + 1, "R9 recovery load accepted", upd_cnt, u0 + 1);
    check_all("R9 recovery contents");

    // R10: load strobe too soon after last clock rise
    u0 = upd_cnt; e0 = err_cnt;
    send_bits({8'h0, 24'h777771}, 24, 10);
    pulse_le(2);
    check(err_cnt == e0 + 1, "R10 early strobe error", err_cnt, e0 + 1);
    check(upd_cnt == u0, "R10 early strobe no update", upd_cnt, u0);
    check_all("R10 latches unchanged");

    // R11: exact latency of a load
    w = 24'h00BEEF;
    send_bits({8'h0, w}, 24, PH);
    wait_cyc(PH);
    ser_le = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check(lat(3) == mdl[3] && !upd_vld, "R11 not before third edge", {8'h0, lat(3)}, {8'h0, mdl[3]});
    @(posedge clk); #1;
    check(lat(3) == w && upd_vld, "R11 at third edge", {8'h0, lat(3)}, {8'h0, w});
    mdl[3] = w;
    wait_cyc(PH);
    ser_le = 1'b0;
    wait_cyc(PH);
    check_all("R11 final contents");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule